// File: doc/BRIEF.md
# APB3 Single-Transfer Manager with Bounded Wait

This block is the requesting side of an APB3 bus. A client hands it one read or write at a time over a valid/ready command port. The block then drives the two-phase bus sequence. One SETUP cycle comes first. The ACCESS phase follows and lasts until the addressed subordinate raises its ready input. The block then presents the read data and an OKAY/ERROR verdict on a response port, which keeps its value until the client accepts it.

A slow or dead subordinate must not hang the bus. A wait counter therefore limits the ACCESS phase to `MAXWAIT` cycles. When that bound is reached without ready, the block drops the select and ends the transfer. It reports a timeout flag, which is kept separate from the subordinate's own error. The block has no byte-strobe or protection outputs, so every write is a full word. It accepts one command at a time: a new command is taken only after the previous response has been consumed.

Top module: `apb_wait_mgr`

## Requirements
- R1: After reset, `psel_o`, `penable_o` and `rsp_valid_o` are low and `cmd_ready_o` is high.
- R2: A command accepted at a clock edge (`cmd_valid_i` and `cmd_ready_o` high) produces exactly one SETUP cycle (`psel_o`=1, `penable_o`=0) in the following cycle. ACCESS (`psel_o`=1, `penable_o`=1) starts in the cycle after that.
- R3: During every ACCESS cycle, `paddr_o`, `pwrite_o` and `pwdata_o` equal the accepted command's address, direction and write data, and they do not change while `pready_i` is low.
- R4: A transfer completes in the ACCESS cycle where `pready_i` is high. In the next cycle `psel_o` and `penable_o` are low and `rsp_valid_o` is high. A subordinate that is always ready therefore gives exactly one ACCESS cycle.
- R5: For a read, `rsp_rdata_o` holds the `prdata_i` value sampled in the completion cycle. For a write, `rsp_rdata_o` is zero.
- R6: `rsp_err_o` holds `pslverr_i` as sampled in the completion cycle (1 = ERROR, 0 = OKAY), and `rsp_tmo_o` is 0 for a transfer that completed.
- R7: If `pready_i` stays low for `MAXWAIT` consecutive ACCESS cycles, the transfer ends after the last of them. The next cycle has `psel_o` low and a response with `rsp_tmo_o`=1, `rsp_err_o`=0 and `rsp_rdata_o`=0. A ready in the `MAXWAIT`-th ACCESS cycle still completes normally.
- R8: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response valid, data, error and timeout outputs stay unchanged.
- R9: `cmd_ready_o` is low from the cycle after acceptance until the response is accepted. A `cmd_valid_i` held high during that time starts no bus activity. `cmd_ready_o` is high again in the cycle after the response handshake.
- R10: Values on `prdata_i` and `pslverr_i` in ACCESS cycles where `pready_i` is low have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Transfer address |
| cmd_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Client takes the response |
| rsp_rdata_o | output | DW | Read data (zero for writes and timeouts) |
| rsp_err_o | output | 1 | Subordinate reported ERROR |
| rsp_tmo_o | output | 1 | Wait bound reached |
| psel_o | output | 1 | Bus select |
| penable_o | output | 1 | ACCESS phase marker |
| pwrite_o | output | 1 | Bus direction |
| paddr_o | output | AW | Bus address |
| pwdata_o | output | DW | Bus write data |
| prdata_i | input | DW | Bus read data |
| pready_i | input | 1 | Subordinate ready |
| pslverr_i | input | 1 | Subordinate error |

## Verification
The bench drives a subordinate model that waits a chosen number of cycles and puts decoy data and a raised error on the bus while it waits. A design that sampled these values outside the completion cycle would return the decoy word or a false ERROR. The ready-at-the-limit case and the never-ready case bracket the wait bound. An off-by-one counter would either time out a legal transfer or allow one extra ACCESS cycle. A failed write is followed by a read of the same location, and the command valid is held high through each transfer. A design that re-armed the command port early would start a second SETUP. Response back-pressure exposes response outputs that drift or drop before the handshake.

// File: rtl/apb_mgr_pkg.sv
package apb_mgr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_RESP   = 2'd3
  } phase_e;
endpackage

// File: rtl/apb_mgr_phase.sv
module apb_mgr_phase
  import apb_mgr_pkg::*;
#(
  parameter int MAXWAIT = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_fire_i,
  input  logic   pready_i,
  input  logic   rsp_take_i,
  output phase_e phase_o,
  output logic   done_o,
  output logic   abort_o
);
  localparam int WCW = (MAXWAIT < 2) ? 1 : $clog2(MAXWAIT);

  phase_e phase_q, phase_d;
  logic [WCW-1:0] wait_q, wait_d;
  logic last_wait;

  assign last_wait = (wait_q == WCW'(MAXWAIT - 1));
  assign done_o    = (phase_q == PH_ACCESS) && pready_i;
  assign abort_o   = (phase_q == PH_ACCESS) && !pready_i && last_wait;

  always_comb begin
    phase_d = phase_q;
    wait_d  = wait_q;
    unique case (phase_q)
      PH_IDLE:   if (cmd_fire_i) phase_d = PH_SETUP;
      PH_SETUP: begin
        phase_d = PH_ACCESS;
        wait_d  = '0;
      end
      PH_ACCESS: begin
        if (done_o || abort_o) phase_d = PH_RESP;
        else                   wait_d  = wait_q + 1'b1;
      end
      PH_RESP:   if (rsp_take_i) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wait_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wait_q  <= wait_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/apb_mgr_req.sv
module apb_mgr_req #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          write_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  // Loaded only on acceptance: bus fields stay fixed for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/apb_mgr_rsp.sv
module apb_mgr_rsp #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          abort_i,
  input  logic          is_write_i,
  input  logic [DW-1:0] prdata_i,
  input  logic          pslverr_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          tmo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      tmo_o   <= 1'b0;
    end else if (done_i) begin
      rdata_o <= is_write_i ? '0 : prdata_i;
      err_o   <= pslverr_i;
      tmo_o   <= 1'b0;
    end else if (abort_i) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      tmo_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/apb_wait_mgr.sv
module apb_wait_mgr
  import apb_mgr_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int MAXWAIT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o,
  output logic          rsp_tmo_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i,
  input  logic          pslverr_i
);
  phase_e phase;
  logic   cmd_fire, rsp_take, done, abort;

  assign cmd_ready_o = (phase == PH_IDLE);
  assign rsp_valid_o = (phase == PH_RESP);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign rsp_take    = rsp_valid_o && rsp_ready_i;
  assign psel_o      = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign penable_o   = (phase == PH_ACCESS);

  apb_mgr_phase #(.MAXWAIT(MAXWAIT)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_fire_i (cmd_fire),
    .pready_i   (pready_i),
    .rsp_take_i (rsp_take),
    .phase_o    (phase),
    .done_o     (done),
    .abort_o    (abort)
  );

  apb_mgr_req #(.AW(AW), .DW(DW)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd_fire),
    .write_i (cmd_write_i),
    .addr_i  (cmd_addr_i),
    .wdata_i (cmd_wdata_i),
    .write_o (pwrite_o),
    .addr_o  (paddr_o),
    .wdata_o (pwdata_o)
  );

  apb_mgr_rsp #(.DW(DW)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .abort_i    (abort),
    .is_write_i (pwrite_o),
    .prdata_i   (prdata_i),
    .pslverr_i  (pslverr_i),
    .rdata_o    (rsp_rdata_o),
    .err_o      (rsp_err_o),
    .tmo_o      (rsp_tmo_o)
  );
endmodule

// File: rtl/apb_wait_mgr_chk.sv
module apb_wait_mgr_chk #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int MAXWAIT = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_ready_o,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          rsp_err_o,
  input logic          rsp_tmo_o,
  input logic          psel_o,
  input logic          penable_o,
  input logic          pwrite_o,
  input logic [AW-1:0] paddr_o,
  input logic [DW-1:0] pwdata_o,
  input logic          pready_i
);
  // Counts ACCESS cycles already spent in the current transfer
  logic [31:0] acc_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  acc_seen_q <= '0;
    else if (psel_o && penable_o) acc_seen_q <= acc_seen_q + 1;
    else                          acc_seen_q <= '0;
  end

  // R2
  setup_then_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !penable_o) |=> (psel_o && penable_o));

  // R3
  access_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && !pready_i) |=>
      ($stable(paddr_o) && $stable(pwrite_o) && $stable(pwdata_o)));

  // R4
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i) |=> (!psel_o && !penable_o && rsp_valid_o));

  // R6
  done_no_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i) |=> !rsp_tmo_o);

  // R7
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o) |-> (acc_seen_q < MAXWAIT));

  // R8
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o) && $stable(rsp_tmo_o)));

  // R9
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o || rsp_valid_o) |-> !cmd_ready_o);

  // R9
  rsp_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !psel_o);
endmodule

bind apb_wait_mgr apb_wait_mgr_chk #(.AW(AW), .DW(DW), .MAXWAIT(MAXWAIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_tmo_o   (rsp_tmo_o),
  .psel_o      (psel_o),
  .penable_o   (penable_o),
  .pwrite_o    (pwrite_o),
  .paddr_o     (paddr_o),
  .pwdata_o    (pwdata_o),
  .pready_i    (pready_i)
);

// File: tb/apb_wait_mgr_bench.sv
module apb_wait_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int MAXW = 8;
  localparam logic [DW-1:0] DECOY = 32'hDEAD_BEEF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_ready = 1'b0;
  logic          cmd_ready, rsp_valid, rsp_err, rsp_tmo;
  logic [DW-1:0] rsp_rdata;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata = '0;
  logic          pready = 1'b0, pslverr = 1'b0;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int wait_n = 0;
  bit err_sel = 1'b0;
  int acc_cnt = 0;
  logic [DW-1:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_wait_mgr #(.AW(AW), .DW(DW), .MAXWAIT(MAXW)) u_apb_wait_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .rsp_tmo_o(rsp_tmo),
    .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .paddr_o(paddr),
    .pwdata_o(pwdata), .prdata_i(prdata), .pready_i(pready), .pslverr_i(pslverr)
  );

  // Subordinate model: ready after wait_n not-ready ACCESS cycles, decoys while waiting
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = 32'h1111_0000 * (i + 1);
      acc_cnt = 0; pready = 1'b0; pslverr = 1'b0; prdata = '0;
    end else if (psel && penable) begin
      if (acc_cnt == wait_n) begin
        pready  = 1'b1;
        pslverr = err_sel;
        prdata  = mem[paddr[5:2]];
        if (pwrite && !err_sel) mem[paddr[5:2]] = pwdata;
      end else begin
        pready  = 1'b0;
        pslverr = 1'b1;
        prdata  = DECOY;
      end
      acc_cnt++;
    end else begin
      acc_cnt = 0; pready = 1'b0; pslverr = 1'b0; prdata = DECOY;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One full transfer; cmd_valid kept high until the response is taken (R9)
  task automatic run_xfer(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, int waits, bit er,
                          bit exp_tmo, logic [DW-1:0] exp_rd, int rsp_delay);
    int n_acc = 0;
    bit fld_ok = 1'b1, busy_ok = 1'b1;
    logic [DW-1:0] r0;
    wait_n = waits; err_sel = er;
    @(negedge clk);
    chk(cmd_ready, "R9 ready before cmd", {31'b0, cmd_ready}, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    chk(psel && !penable, "R2 setup phase", {30'b0, psel, penable}, 32'h2);
    cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = ~wd;  // must not leak onto the bus
    @(negedge clk);
    while (psel && penable) begin
      n_acc++;
      if (paddr != a || pwrite != wr || (wr && pwdata != wd)) fld_ok = 1'b0;
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    chk(fld_ok, "R3 bus fields held", {20'b0, paddr}, {20'b0, a});
    chk(busy_ok && !cmd_ready, "R9 busy during transfer", {31'b0, cmd_ready}, 0);
    if (exp_tmo) chk(n_acc == MAXW, "R7 access count at bound", n_acc, MAXW);
    else         chk(n_acc == waits + 1, "R4 access count", n_acc, waits + 1);
    chk(rsp_valid && !psel && !penable, "R4 release and respond",
        {29'b0, rsp_valid, psel, penable}, 32'h4);
    chk(rsp_rdata == exp_rd, exp_tmo ? "R7 rdata" : (wr ? "R5 write rdata" : "R5 R10 rdata"),
        rsp_rdata, exp_rd);
    chk(rsp_err == (er && !exp_tmo), exp_tmo ? "R7 err" : "R6 R10 err",
        {31'b0, rsp_err}, {31'b0, er && !exp_tmo});
    chk(rsp_tmo == exp_tmo, exp_tmo ? "R7 tmo" : "R6 tmo",
        {31'b0, rsp_tmo}, {31'b0, exp_tmo});
    r0 = rsp_rdata;
    for (int i = 0; i < rsp_delay; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == r0 && !psel && !cmd_ready, "R8 R9 hold under backpressure",
          rsp_rdata, r0);
    end
    cmd_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready && !psel, "R9 ready after response",
        {30'b0, rsp_valid, cmd_ready}, 32'h1);
  endtask

  task automatic t_reset();
    chk(!psel && !penable && !rsp_valid && cmd_ready, "R1 reset state",
        {28'b0, psel, penable, rsp_valid, cmd_ready}, 32'h1);
  endtask

  task automatic t_zero_wait();
    run_xfer(1'b1, 12'h010, 32'hA5A5_0001, 0, 1'b0, 1'b0, 32'h0, 0);
    run_xfer(1'b0, 12'h010, 32'h0, 0, 1'b0, 1'b0, 32'hA5A5_0001, 0);
  endtask

  task automatic t_waits();
    run_xfer(1'b0, 12'h008, 32'h0, 3, 1'b0, 1'b0, 32'h3333_0000, 0);
    run_xfer(1'b1, 12'h020, 32'h0BAD_F00D, 2, 1'b0, 1'b0, 32'h0, 0);
    run_xfer(1'b0, 12'h020, 32'h0, 1, 1'b0, 1'b0, 32'h0BAD_F00D, 0);
  endtask

  task automatic t_errors();
    // failed write leaves location unchanged in the subordinate; read returns old value
    run_xfer(1'b1, 12'h00C, 32'h1234_5678, 2, 1'b1, 1'b0, 32'h0, 0);
    run_xfer(1'b0, 12'h00C, 32'h0, 0, 1'b1, 1'b0, 32'h4444_0000, 0);
  endtask

  task automatic t_bound();
    run_xfer(1'b0, 12'h004, 32'h0, MAXW - 1, 1'b0, 1'b0, 32'h2222_0000, 0);
    run_xfer(1'b0, 12'h004, 32'h0, 1000, 1'b0, 1'b1, 32'h0, 0);
    run_xfer(1'b1, 12'h004, 32'h7777_7777, 1000, 1'b0, 1'b1, 32'h0, 0);
  endtask

  task automatic t_backpressure();
    run_xfer(1'b0, 12'h018, 32'h0, 1, 1'b1, 1'b0, 32'h7777_0000, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_wait();
    t_waits();
    t_errors();
    t_bound();
    t_backpressure();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule